// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block carries out the processor side of a prioritized interrupt acknowledge. While idle it watches for an instruction boundary (or the end of higher-priority exception work) with a pending request level that beats the current priority mask. Once a request is accepted, it issues a status update: the supervisor bit is set, both trace bits are cleared, and the accepted level is loaded into the priority mask. It then runs a CPU-space bus cycle whose address carries the level.

The cycle can end in three ways. A responder can return a vector number on the data bus with a data acknowledge. It can ask for an autovector instead. Or a bus error can end the cycle, either because no arbitration number answered or because the bus monitor expired; a bus error yields the spurious vector. The resolved vector number is scaled by four and added to a vector base. The result is presented for one cycle as the address of the next program-counter fetch.

Stacking, the instruction fetch itself and the arbitration among peripherals are handled elsewhere.

Top module: `irq_ack_seq`

## Requirements
- R1: A request is accepted only while the sequencer is idle and `at_boundary` is high, and only if `req_lvl` is 7 or `req_lvl` is strictly greater than `cur_mask`. Level 0 is never accepted.
- R2: In the cycle after acceptance, `st_upd` is high for exactly one cycle, meaning supervisor set to 1 and trace bits T1 and T0 cleared to 0. In that cycle `st_ipm` equals the accepted level. Both outputs are 0 at all other times.
- R3: While `bus_cyc` is high, `fc` is 3'b111 (CPU space). At all other times it is 3'b000.
- R4: While `bus_cyc` is high, `addr[23:4]` are all ones, `addr[3:1]` hold the accepted level and `addr[0]` is 1. At all other times `addr` is zero.
- R5: The level is captured at acceptance. Later changes on `req_lvl` or `cur_mask` have no effect on `addr`, `st_ipm` or the vector until the sequence ends.
- R6: A cycle ended by `dsack` alone resolves to the vector number on `data_in`, and `vec_kind` is 2'b01.
- R7: A cycle ended by `avec` without `berr` resolves to vector 24 plus the level, and `vec_kind` is 2'b10.
- R8: A cycle ended by `berr` resolves to spurious vector 24, and `vec_kind` is 2'b11.
- R9: When several terminations arrive in the same cycle, `berr` wins over `avec`, and `avec` wins over `dsack`.
- R10: `bus_cyc` drops in the cycle after the terminating edge. In that same cycle `vec_valid` is high for one cycle, with `vec_addr` = `vec_base` + 4 × vector. Outside that cycle `vec_num`, `vec_kind` and `vec_addr` are zero. The sequencer is idle one cycle later.
- R11: With no termination present, `bus_cyc` stays high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Instruction boundary reached / higher exception work done |
| req_lvl | input | 3 | Pending interrupt request level |
| cur_mask | input | 3 | Current interrupt priority mask |
| dsack | input | 1 | Data acknowledge with vector on data bus |
| avec | input | 1 | Autovector request |
| berr | input | 1 | Bus error termination |
| data_in | input | 8 | Data bus carrying the vector number |
| vec_base | input | 32 | Vector table base address |
| bus_cyc | output | 1 | Acknowledge bus cycle in progress |
| fc | output | 3 | Function code |
| addr | output | 24 | Acknowledge cycle address |
| st_upd | output | 1 | Status update strobe (S=1, T1=T0=0, mask load) |
| st_ipm | output | 3 | New interrupt priority mask value |
| vec_valid | output | 1 | Resolved vector address valid |
| vec_num | output | 8 | Resolved vector number |
| vec_kind | output | 2 | 01 external, 10 autovector, 11 spurious |
| vec_addr | output | 32 | Vector table entry address for the next fetch |

## Verification
The terminations collide when two or three strobes land on the same clock edge of the acknowledge cycle. The bench causes this by raising `berr` together with `avec` and `dsack`, and then `avec` together with `dsack`. The reference model decides the winner from the stated priority, and the vector number, kind and address are compared on the following cycle. A second overlap comes from a request level that changes, and a boundary that stays high, while a sequence is in flight. The model must show that neither re-triggers acceptance nor alters the carried level.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int LVL_W  = 3;
    localparam int FC_W   = 3;
    localparam int KIND_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ENTER = 2'd1,
        PH_CYCLE = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    localparam logic [KIND_W-1:0] KIND_NONE = 2'b00;
    localparam logic [KIND_W-1:0] KIND_EXT  = 2'b01;
    localparam logic [KIND_W-1:0] KIND_AUTO = 2'b10;
    localparam logic [KIND_W-1:0] KIND_SPUR = 2'b11;

    localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;
endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_ack_pkg::*;
(
    input  logic [LVL_W-1:0] req_lvl,
    input  logic [LVL_W-1:0] cur_mask,
    output logic             take
);
    localparam logic [LVL_W-1:0] NMI_LVL = '1;

    always_comb begin
        if (req_lvl == NMI_LVL) begin
            take = 1'b1;
        end else begin
            take = (req_lvl > cur_mask);
        end
    end
endmodule

// File: rtl/irq_term_resolve.sv
module irq_term_resolve
    import irq_ack_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int SPUR_VEC  = 24,
    parameter int AUTO_BASE = 24
) (
    input  logic [LVL_W-1:0]  lvl,
    input  logic              dsack,
    input  logic              avec,
    input  logic              berr,
    input  logic [VEC_W-1:0]  data_in,
    output logic              hit,
    output logic [VEC_W-1:0]  vnum,
    output logic [KIND_W-1:0] kind
);
    localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);
    localparam logic [VEC_W-1:0] AUTO_B = VEC_W'(AUTO_BASE);

    always_comb begin
        hit  = 1'b0;
        vnum = '0;
        kind = KIND_NONE;
        if (berr) begin
            hit  = 1'b1;
            vnum = SPUR_V;
            kind = KIND_SPUR;
        end else if (avec) begin
            hit  = 1'b1;
            vnum = AUTO_B + VEC_W'(lvl);
            kind = KIND_AUTO;
        end else if (dsack) begin
            hit  = 1'b1;
            vnum = data_in;
            kind = KIND_EXT;
        end
    end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
    parameter int VEC_W = 8,
    parameter int PC_W  = 32
) (
    input  logic [PC_W-1:0]  base,
    input  logic [VEC_W-1:0] vnum,
    output logic [PC_W-1:0]  vaddr
);
    localparam int SCALE_SH = 2;
    logic [PC_W-1:0] offset;

    always_comb begin
        offset = PC_W'(vnum) << SCALE_SH;
        vaddr  = base + offset;
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int VEC_W     = 8,
    parameter int PC_W      = 32,
    parameter int SPUR_VEC  = 24,
    parameter int AUTO_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  logic [2:0]        req_lvl,
    input  logic [2:0]        cur_mask,
    input  logic              dsack,
    input  logic              avec,
    input  logic              berr,
    input  logic [VEC_W-1:0]  data_in,
    input  logic [PC_W-1:0]   vec_base,
    output logic              bus_cyc,
    output logic [2:0]        fc,
    output logic [ADDR_W-1:0] addr,
    output logic              st_upd,
    output logic [2:0]        st_ipm,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_num,
    output logic [1:0]        vec_kind,
    output logic [PC_W-1:0]   vec_addr
);
    localparam int HI_W = ADDR_W - LVL_W - 1;

    typedef struct packed {
        phase_e              ph;
        logic [LVL_W-1:0]    lvl;
        logic [VEC_W-1:0]    vnum;
        logic [KIND_W-1:0]   kind;
        logic [PC_W-1:0]     vaddr;
    } seq_t;

    seq_t s_d, s_q;

    logic              take;
    logic              term_hit;
    logic [VEC_W-1:0]  term_vnum;
    logic [KIND_W-1:0] term_kind;
    logic [PC_W-1:0]   term_vaddr;

    irq_level_gate u_gate (
        .req_lvl  (req_lvl),
        .cur_mask (cur_mask),
        .take     (take)
    );

    irq_term_resolve #(
        .VEC_W     (VEC_W),
        .SPUR_VEC  (SPUR_VEC),
        .AUTO_BASE (AUTO_BASE)
    ) u_res (
        .lvl     (s_q.lvl),
        .dsack   (dsack),
        .avec    (avec),
        .berr    (berr),
        .data_in (data_in),
        .hit     (term_hit),
        .vnum    (term_vnum),
        .kind    (term_kind)
    );

    irq_vec_calc #(
        .VEC_W (VEC_W),
        .PC_W  (PC_W)
    ) u_calc (
        .base  (vec_base),
        .vnum  (term_vnum),
        .vaddr (term_vaddr)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                s_d.vnum  = '0;
                s_d.kind  = KIND_NONE;
                s_d.vaddr = '0;
                if (at_boundary && take) begin
                    s_d.ph  = PH_ENTER;
                    s_d.lvl = req_lvl;
                end
            end
            PH_ENTER: begin
                s_d.ph = PH_CYCLE;
            end
            PH_CYCLE: begin
                if (term_hit) begin
                    s_d.ph    = PH_DONE;
                    s_d.vnum  = term_vnum;
                    s_d.kind  = term_kind;
                    s_d.vaddr = term_vaddr;
                end
            end
            PH_DONE: begin
                s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, lvl: '0, vnum: '0, kind: KIND_NONE, vaddr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_cyc   = (s_q.ph == PH_CYCLE);
        fc        = bus_cyc ? FC_CPU_SPACE : '0;
        addr      = bus_cyc ? {{HI_W{1'b1}}, s_q.lvl, 1'b1} : '0;
        st_upd    = (s_q.ph == PH_ENTER);
        st_ipm    = st_upd ? s_q.lvl : '0;
        vec_valid = (s_q.ph == PH_DONE);
        vec_num   = vec_valid ? s_q.vnum  : '0;
        vec_kind  = vec_valid ? s_q.kind  : '0;
        vec_addr  = vec_valid ? s_q.vaddr : '0;
    end
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dsack,
    input logic        avec,
    input logic        berr,
    input logic        bus_cyc,
    input logic [2:0]  fc,
    input logic [23:0] addr,
    input logic        st_upd,
    input logic [2:0]  st_ipm,
    input logic        vec_valid,
    input logic [7:0]  vec_num,
    input logic [1:0]  vec_kind
);
    logic [2:0] ipm_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) ipm_seen <= '0;
        else if (st_upd) ipm_seen <= st_ipm;
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cyc, st_upd, vec_valid})); // R2
    AST_ENTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        st_upd |=> bus_cyc); // R2
    AST_FC_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> fc == 3'b111); // R3
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (addr[23:4] == 20'hFFFFF && addr[0])); // R4
    AST_LVL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> addr[3:1] == ipm_seen); // R5
    AST_SPUR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && berr) |=> (vec_num == 8'd24 && vec_kind == 2'b11)); // R8
    AST_AUTO_OVER_DS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !berr && avec) |=> vec_kind == 2'b10); // R9
    AST_DROP_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && (berr || avec || dsack)) |=> (!bus_cyc && vec_valid)); // R10
    AST_HOLD_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !berr && !avec && !dsack) |=> bus_cyc); // R11
endmodule

bind irq_ack_seq irq_ack_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dsack     (dsack),
    .avec      (avec),
    .berr      (berr),
    .bus_cyc   (bus_cyc),
    .fc        (fc),
    .addr      (addr),
    .st_upd    (st_upd),
    .st_ipm    (st_ipm),
    .vec_valid (vec_valid),
    .vec_num   (vec_num),
    .vec_kind  (vec_kind)
);

// File: tb/sim_irq_ack_seq.sv
`timescale 1ns/1ps
module sim_irq_ack_seq;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        at_boundary = 1'b0;
    logic [2:0]  req_lvl = '0;
    logic [2:0]  cur_mask = '0;
    logic        dsack = 1'b0;
    logic        avec = 1'b0;
    logic        berr = 1'b0;
    logic [7:0]  data_in = '0;
    logic [31:0] vec_base = 32'h0000_1000;
    logic        bus_cyc;
    logic [2:0]  fc;
    logic [23:0] addr;
    logic        st_upd;
    logic [2:0]  st_ipm;
    logic        vec_valid;
    logic [7:0]  vec_num;
    logic [1:0]  vec_kind;
    logic [31:0] vec_addr;

    always #(CLK_PER/2) clk = ~clk;

    irq_ack_seq u0 (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .req_lvl(req_lvl),
        .cur_mask(cur_mask), .dsack(dsack), .avec(avec), .berr(berr),
        .data_in(data_in), .vec_base(vec_base), .bus_cyc(bus_cyc), .fc(fc),
        .addr(addr), .st_upd(st_upd), .st_ipm(st_ipm), .vec_valid(vec_valid),
        .vec_num(vec_num), .vec_kind(vec_kind), .vec_addr(vec_addr)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference: step 0 idle, 1 status, 2 bus cycle, 3 vector out
    int m_step = 0;
    int m_lvl = 0;
    int m_vn = 0;
    int m_kind = 0;
    longint m_va = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_lvl = 0; m_vn = 0; m_kind = 0; m_va = 0;
        end else if (m_step == 0) begin
            if (at_boundary && (req_lvl == 7 || int'(req_lvl) > int'(cur_mask))) begin
                m_step = 1; m_lvl = int'(req_lvl);
            end
        end else if (m_step == 1) begin
            m_step = 2;
        end else if (m_step == 2) begin
            if (berr)       begin m_vn = 24;           m_kind = 3; end
            else if (avec)  begin m_vn = 24 + m_lvl;   m_kind = 2; end
            else if (dsack) begin m_vn = int'(data_in); m_kind = 1; end
            if (berr || avec || dsack) begin
                m_va = (longint'(vec_base) + 4 * m_vn) & 64'hFFFF_FFFF;
                m_step = 3;
            end
        end else begin
            m_step = 0;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            string vt;
            n_vec++;
            vt = (m_kind == 1) ? "R6" : (m_kind == 2) ? "R7" : "R8";
            chk("R1", "bus_cyc", bus_cyc, m_step == 2);
            chk("R3", "fc", fc, (m_step == 2) ? 7 : 0);
            chk("R4", "addr", addr, (m_step == 2) ? ((24'hFFFFF << 4) | (m_lvl << 1) | 1) : 0);
            chk("R2", "st_upd", st_upd, m_step == 1);
            chk("R5", "st_ipm", st_ipm, (m_step == 1) ? m_lvl : 0);
            chk("R10", "vec_valid", vec_valid, m_step == 3);
            chk(vt, "vec_num", vec_num, (m_step == 3) ? m_vn : 0);
            chk(vt, "vec_kind", vec_kind, (m_step == 3) ? m_kind : 0);
            chk("R10", "vec_addr", vec_addr, (m_step == 3) ? m_va : 0);
        end
    end

    // one request; responder raises the given strobes after dly cycles of bus_cyc
    task automatic run_case(input logic [2:0] lv, input logic [2:0] mk,
                            input logic b, input logic a, input logic d,
                            input logic [7:0] dat, input int dly, input bit wiggle);
        @(posedge clk); #1;
        req_lvl = lv; cur_mask = mk; at_boundary = 1'b1;
        for (int i = 0; i < 4 && !bus_cyc; i++) begin
            @(posedge clk); #1;
            if (wiggle) begin req_lvl = 3'd7; cur_mask = 3'd0; end // R5
        end
        if (bus_cyc) begin
            for (int i = 0; i < dly; i++) begin
                @(posedge clk); #1;
            end
            berr = b; avec = a; dsack = d; data_in = dat;
            @(posedge clk); #1;
            berr = 0; avec = 0; dsack = 0; data_in = 8'h00;
        end
        at_boundary = 1'b0; req_lvl = 0; cur_mask = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1", "reset bus_cyc", bus_cyc, 0);
        chk("R10", "reset vec_valid", vec_valid, 0);
        run_case(3'd5, 3'd2, 0, 0, 1, 8'h40, 2, 0);  // R6 external vector
        run_case(3'd3, 3'd0, 0, 1, 0, 8'h00, 0, 0);  // R7 autovector
        run_case(3'd1, 3'd0, 1, 0, 0, 8'h00, 5, 0);  // R8 spurious
        run_case(3'd4, 3'd1, 1, 1, 1, 8'h77, 1, 0);  // R9 all three together
        run_case(3'd6, 3'd2, 0, 1, 1, 8'h99, 1, 0);  // R9 avec over dsack
        run_case(3'd7, 3'd7, 0, 0, 1, 8'hFF, 0, 0);  // R1 level 7 beats mask 7
        run_case(3'd3, 3'd3, 0, 0, 1, 8'h10, 0, 0);  // R1 equal level refused
        run_case(3'd2, 3'd5, 0, 0, 1, 8'h10, 0, 0);  // R1 lower level refused
        run_case(3'd0, 3'd0, 0, 0, 1, 8'h10, 0, 0);  // R1 level 0 refused
        run_case(3'd2, 3'd1, 0, 1, 0, 8'h00, 20, 1); // R11 long hold, R5 wiggle
        vec_base = 32'hFFFF_FFF0;
        run_case(3'd6, 3'd0, 0, 0, 1, 8'hFF, 1, 0);  // R10 address wrap
        @(posedge clk); #1;
        at_boundary = 1'b0; req_lvl = 3'd4;          // R1 no boundary
        repeat (4) @(posedge clk);
        req_lvl = 0;
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule